// File: doc/BRIEF.md
# Coincident-Current Core Memory Sequencer

This block sequences accesses to a 64-byte ferrite core store built from eight bit-planes, one plane per data bit. All planes share sixteen drive lines, eight rows and eight columns. Each line has its own active-low select, and one common polarity output sets the direction of every driven line. A core flips only where a driven row crosses a driven column. A host presents a 6-bit address, a write flag and 8-bit write data on a valid/ready handshake. The sequencer then runs two timed drive pulses per access, with quiet gaps around each one.

The first pulse always drives the addressed word toward 0. Planes whose core held a 1 report a sense pulse, and a capture register latches the sense vector at the end of that pulse. The second pulse drives toward 1, and the per-plane inhibit outputs hold back every bit that must stay 0. On a read, the second pulse writes back the captured word, so the destructive read leaves the contents unchanged. On a write, it stores the new data.

A self-test mode loops writing 0, reading, writing all ones and reading at one chosen address. It sets a sticky error flag on any mismatch.

Top module: `core_mem_seq`

## Requirements
- R1: Address bits [5:3] pick the row line and bits [2:0] pick the column line. A select is active when low. At most one row select and one column select are low at a time, and the row and column selects are always active together.
- R2: Every drive pulse keeps its selects low for exactly PULSE_CYC consecutive clock cycles.
- R3: Before any pulse, every select has been inactive for at least DEAD_CYC cycles. The polarity output changes only in a cycle where the selects are inactive and were also inactive in the cycle before.
- R4: The first pulse of every access has polarity 0, which drives toward 0. The sense strobe is high only in the last cycle of that pulse, and the sense vector is captured at the clock edge ending that cycle. After a read, rd_data equals the captured bits.
- R5: After a read, the second pulse has polarity 1 with inhibit[i] high for every bit i that was captured as 0. This restores the word, so a second read of the same address returns the same value.
- R6: A write runs the clear pulse and then a set pulse with inhibit equal to the inverted write data. Afterwards the addressed word holds the write data, and rd_valid stays low.
- R7: req_ready is high only when the sequencer is idle and test_en is low. A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready returns exactly 2*PULSE_CYC+4*DEAD_CYC cycles after the accepting edge, and for a read rd_valid is high for that one cycle.
- R8: Every inhibit output is low whenever the polarity output is 0.
- R9: While test_en is high, host requests are refused (req_ready low). The block repeats write 0, read, write all ones, read at test_addr, and drives no other address.
- R10: test_err is set when a self-test read differs from the value just written. Once set, it stays high until reset.
- R11: After reset, all selects are high, polarity, inhibit, strobe, rd_valid and test_err are low, and req_ready is high while test_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse when read data is ready |
| rd_data | output | 8 | Captured read word |
| row_sel_n | output | 8 | Active-low row drive selects |
| col_sel_n | output | 8 | Active-low column drive selects |
| drive_pol | output | 1 | Drive direction: 0 toward 0, 1 toward 1 |
| inhibit | output | 8 | Per-plane inhibit, high keeps the bit at 0 |
| sense_strobe | output | 1 | High in the cycle whose closing edge captures the sense vector |
| sense_in | input | 8 | Per-plane sense pulses |
| test_en | input | 1 | Enables the self-test loop |
| test_addr | input | 6 | Address exercised by the self-test |
| test_err | output | 1 | Sticky self-test mismatch flag |

## Verification
Every access has a fixed length. The bench counts clock edges from the edge that accepts a request and expects req_ready, and for reads rd_valid, in the cycle after edge 2*PULSE_CYC+4*DEAD_CYC. It samples on the falling edge of that cycle. The stored contents are only checked after that point, because the modelled cores change state when a pulse ends. The core model updates its store at the falling edge where the selects are seen released. Pulse length, gap length and strobe position are counted in falling-edge samples, so the strobe must appear on exactly the PULSE_CYC-th sample of the clear pulse.

// File: rtl/cm_pkg.sv
package cm_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_GAP0,
      PH_CLR,
      PH_HOLD,
      PH_GAP1,
      PH_SET,
      PH_TAIL
   } phase_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cm_line_decode.sv
module cm_line_decode #(
   parameter int SEL_BITS = 3
) (
   input  logic [SEL_BITS-1:0]      idx_i,
   input  logic                     en_i,
   output logic [(1<<SEL_BITS)-1:0] sel_n_o
);
   localparam int LINES = 1 << SEL_BITS;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      assign sel_n_o[g] = ~(en_i && (idx_i == SEL_BITS'(g)));
   end

endmodule

// File: rtl/cm_phase_seq.sv
module cm_phase_seq
   import cm_pkg::*;
#(
   parameter int PULSE_CYC = 63,
   parameter int DEAD_CYC  = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   output phase_e phase_o,
   output logic   last_o,
   output logic   done_o
);
   localparam int MAXLEN = max2(PULSE_CYC, DEAD_CYC);
   localparam int CW     = $clog2(MAXLEN + 1);

   phase_e        phase_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;

   function automatic logic [CW-1:0] len_of(input phase_e p);
      if (p == PH_CLR || p == PH_SET) return CW'(PULSE_CYC - 1);
      return CW'(DEAD_CYC - 1);
   endfunction

   function automatic phase_e succ(input phase_e p);
      case (p)
         PH_GAP0: return PH_CLR;
         PH_CLR:  return PH_HOLD;
         PH_HOLD: return PH_GAP1;
         PH_GAP1: return PH_SET;
         PH_SET:  return PH_TAIL;
         default: return PH_IDLE;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (phase_q == PH_IDLE) begin
            if (start_i) begin
               phase_q <= PH_GAP0;
               cnt_q   <= len_of(PH_GAP0);
            end
         end else if (cnt_q == '0) begin
            phase_q <= succ(phase_q);
            cnt_q   <= len_of(succ(phase_q));
            if (phase_q == PH_TAIL) done_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign phase_o = phase_q;
   assign last_o  = (phase_q == PH_CLR) && (cnt_q == '0);
   assign done_o  = done_q;

   // R4: the strobe cycle closes the clear pulse
   a_r4_strobe_ends_clear: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> (phase_q == PH_HOLD));

   // R7: a finished access lands in idle
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(phase_q == PH_TAIL));

endmodule

// File: rtl/cm_self_test.sv
module cm_self_test #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              idle_i,
   input  logic              done_i,
   input  logic [DATA_W-1:0] cap_i,
   output logic              start_o,
   output logic              write_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              err_o
);
   logic [1:0]        step_q;
   logic              busy_q;
   logic              err_q;
   logic [DATA_W-1:0] pattern;

   assign pattern = step_q[1] ? '1 : '0;
   assign start_o = en_i && idle_i && !done_i && !busy_q;
   assign write_o = !step_q[0];
   assign wdata_o = pattern;
   assign err_o   = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         busy_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (start_o) busy_q <= 1'b1;
         if (done_i && busy_q) begin
            busy_q <= 1'b0;
            step_q <= step_q + 1'b1;
            if (step_q[0] && (cap_i != pattern)) err_q <= 1'b1;
         end else if (!en_i && !busy_q) begin
            step_q <= '0;
         end
      end
   end

   // R10: the flag never drops without reset
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   // R9: a self-test launch takes the sequencer out of idle
   a_r9_launch_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !idle_i);

endmodule

// File: rtl/core_mem_seq.sv
module core_mem_seq
   import cm_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int PULSE_CYC = 63,
   parameter int DEAD_CYC  = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic                        req_write,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   output logic                        rd_valid,
   output logic [DATA_W-1:0]           rd_data,
   output logic [(1<<(ADDR_W/2))-1:0]  row_sel_n,
   output logic [(1<<(ADDR_W/2))-1:0]  col_sel_n,
   output logic                        drive_pol,
   output logic [DATA_W-1:0]           inhibit,
   output logic                        sense_strobe,
   input  logic [DATA_W-1:0]           sense_in,
   input  logic                        test_en,
   input  logic [ADDR_W-1:0]           test_addr,
   output logic                        test_err
);
   localparam int SEL_BITS = ADDR_W / 2;
   localparam int LINES    = 1 << SEL_BITS;
   localparam int RUN_W    = $clog2(max2(PULSE_CYC, DEAD_CYC) + 2);

   if (ADDR_W < 2 || (ADDR_W % 2) != 0) begin : g_bad_addr
      $error("ADDR_W must be even and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end
   if (PULSE_CYC < 1 || DEAD_CYC < 1) begin : g_bad_time
      $error("PULSE_CYC and DEAD_CYC must be at least 1");
   end

   phase_e              phase;
   logic                last_cyc;
   logic                done;
   logic                start;
   logic                host_fire;
   logic                st_start, st_write;
   logic [DATA_W-1:0]   st_wdata;
   logic                op_write_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [DATA_W-1:0]   cap_q;
   logic [DATA_W-1:0]   word_b;
   logic                active;
   logic                idle;

   assign idle      = (phase == PH_IDLE);
   assign req_ready = idle && !test_en;
   assign host_fire = req_valid && req_ready;
   assign start     = host_fire || st_start;

   cm_phase_seq #(.PULSE_CYC(PULSE_CYC), .DEAD_CYC(DEAD_CYC)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .phase_o (phase),
      .last_o  (last_cyc),
      .done_o  (done)
   );

   cm_self_test #(.DATA_W(DATA_W)) u_test (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (test_en),
      .idle_i  (idle),
      .done_i  (done),
      .cap_i   (cap_q),
      .start_o (st_start),
      .write_o (st_write),
      .wdata_o (st_wdata),
      .err_o   (test_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_write_q <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
      end else if (start) begin
         op_write_q <= test_en ? st_write : req_write;
         addr_q     <= test_en ? test_addr : req_addr;
         wdata_q    <= test_en ? st_wdata : req_wdata;
      end
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_plane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cap_q[b] <= 1'b0;
         else if (last_cyc) cap_q[b] <= sense_in[b];
      end
   end

   assign active       = (phase == PH_CLR) || (phase == PH_SET);
   assign drive_pol    = (phase == PH_GAP1) || (phase == PH_SET) || (phase == PH_TAIL);
   assign word_b       = op_write_q ? wdata_q : cap_q;
   assign inhibit      = drive_pol ? ~word_b : '0;
   assign sense_strobe = last_cyc;
   assign rd_data      = cap_q;
   assign rd_valid     = done && !op_write_q;

   cm_line_decode #(.SEL_BITS(SEL_BITS)) u_row (
      .idx_i   (addr_q[ADDR_W-1 -: SEL_BITS]),
      .en_i    (active),
      .sel_n_o (row_sel_n)
   );

   cm_line_decode #(.SEL_BITS(SEL_BITS)) u_col (
      .idx_i   (addr_q[SEL_BITS-1:0]),
      .en_i    (active),
      .sel_n_o (col_sel_n)
   );

   // ---- checking support: run and gap lengths seen at the select pins ----
   logic             sel_on;
   logic             was_on_q;
   logic [RUN_W-1:0] run_q, gap_q;
   localparam logic [RUN_W-1:0] RUN_MAX = '1;

   assign sel_on = (row_sel_n != '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         was_on_q <= 1'b0;
         run_q    <= '0;
         gap_q    <= RUN_MAX;
      end else begin
         was_on_q <= sel_on;
         run_q    <= sel_on ? ((run_q == RUN_MAX) ? run_q : run_q + 1'b1) : '0;
         gap_q    <= sel_on ? '0 : ((gap_q == RUN_MAX) ? gap_q : gap_q + 1'b1);
      end
   end

   // R1: rows and columns are driven together and never two at once
   a_r1_pair_together: assert property (@(posedge clk) disable iff (!rst_n)
      ((row_sel_n == '1) == (col_sel_n == '1)) &&
      ($countones(~row_sel_n) <= 1) && ($countones(~col_sel_n) <= 1));

   // R2: each pulse lasts exactly the programmed length
   a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_on && was_on_q) |-> (run_q == RUN_W'(PULSE_CYC)));

   // R3: quiet gap before new selects
   a_r3_gap_before: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_on && !was_on_q) |-> (gap_q >= RUN_W'(DEAD_CYC)));

   // R3: polarity moves only with selects released for two cycles
   a_r3_pol_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_pol != $past(drive_pol)) |-> (!sel_on && !was_on_q));

   // R4: strobe is followed by released selects
   a_r4_strobe_release: assert property (@(posedge clk) disable iff (!rst_n)
      sense_strobe |-> (sel_on && !drive_pol) ##1 !sel_on);

   // R8: inhibit only while driving toward 1
   a_r8_inhibit_pol: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit != '0) |-> drive_pol);

   // R7: an accepted request drops ready
   a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/core_mem_seq_tb_top.sv
module core_mem_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int P_CYC      = 12;
   localparam int D_CYC      = 2;
   localparam int LAT        = 2 * P_CYC + 4 * D_CYC;
   localparam int WD_LIMIT   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_write = 1'b0;
   logic [5:0] req_addr = '0, test_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       test_en = 1'b0;
   logic       req_ready, rd_valid, drive_pol, sense_strobe, test_err;
   logic [7:0] rd_data, row_sel_n, col_sel_n, inhibit, sense_in;

   int total = 0, bad = 0, cyc = 0;
   bit finished = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   core_mem_seq #(.ADDR_W(6), .DATA_W(8), .PULSE_CYC(P_CYC), .DEAD_CYC(D_CYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .row_sel_n(row_sel_n),
      .col_sel_n(col_sel_n), .drive_pol(drive_pol), .inhibit(inhibit),
      .sense_strobe(sense_strobe), .sense_in(sense_in), .test_en(test_en),
      .test_addr(test_addr), .test_err(test_err)
   );

   // ---------------- core plane model ----------------
   logic [7:0] mem [64];
   logic [5:0] stuck_addr = '0;
   logic [7:0] stuck_mask = '0;
   logic [5:0] cur_addr;
   logic       cur_on;
   logic       was_on = 1'b0, was_pol = 1'b0;
   logic [5:0] was_addr = '0;
   logic [7:0] was_inh = '0;
   int         run_m = 0, gap_m = 1000;
   int         pulses = 0, far_pulses = 0;
   bit         pair_bad = 0, inh_bad = 0, pol_bad = 0;
   logic [5:0] last_clr_addr = '0, last_set_addr = '0;
   bit         watch_addr = 0;
   bit         saw_zero = 0, saw_ones = 0;

   function automatic int low_idx(input logic [7:0] v);
      for (int i = 0; i < 8; i++) if (!v[i]) return i;
      return 0;
   endfunction

   always_comb begin
      cur_on   = (row_sel_n != 8'hFF);
      cur_addr = {3'(low_idx(row_sel_n)), 3'(low_idx(col_sel_n))};
      sense_in = (cur_on && !drive_pol) ? mem[cur_addr] : 8'h00;
   end

   initial for (int i = 0; i < 64; i++) mem[i] = 8'h00;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (($countones(~row_sel_n) > 1) || ($countones(~col_sel_n) > 1) ||
             ((row_sel_n == 8'hFF) != (col_sel_n == 8'hFF))) pair_bad = 1;
         if (inhibit != 8'h00 && !drive_pol) inh_bad = 1;
         if (drive_pol != was_pol && (cur_on || was_on)) pol_bad = 1;
         if (cur_on) run_m++;
         if (sense_strobe)
            chk(cur_on && !drive_pol && run_m == P_CYC, "R4 strobe position", run_m, P_CYC);
         if (cur_on && !was_on)
            chk(gap_m >= D_CYC, "R3 gap before pulse", gap_m, D_CYC);
         if (!cur_on && was_on) begin
            chk(run_m == P_CYC, "R2 pulse length", run_m, P_CYC);
            pulses++;
            if (watch_addr && was_addr != test_addr) far_pulses++;
            if (!was_pol) begin
               mem[was_addr] = 8'h00;
               last_clr_addr = was_addr;
            end else begin
               mem[was_addr] = mem[was_addr] | (~was_inh &
                  ((was_addr == stuck_addr) ? ~stuck_mask : 8'hFF));
               last_set_addr = was_addr;
               if (watch_addr && mem[was_addr] == 8'h00) saw_zero = 1;
               if (watch_addr && mem[was_addr] == 8'hFF) saw_ones = 1;
            end
            run_m = 0;
         end
         gap_m   = cur_on ? 0 : gap_m + 1;
         was_on  = cur_on;
         was_pol = drive_pol;
         if (cur_on) begin
            was_addr = cur_addr;
            was_inh  = inhibit;
         end
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- host side ----------------
   logic [7:0] shadow [64];

   task automatic do_op(input bit wr, input logic [5:0] a, input logic [7:0] d,
                        output logic [7:0] rdata, output int lat, output bit rv);
      int guard = 0;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready && guard < 2000) begin @(negedge clk); guard++; end
      @(posedge clk);
      lat = 0;
      @(negedge clk);
      req_valid = 0;
      while (!req_ready && lat < 2000) begin
         @(posedge clk); lat++; @(negedge clk);
      end
      rdata = rd_data;
      rv = rd_valid;
   endtask

   task automatic host_write(input logic [5:0] a, input logic [7:0] d);
      logic [7:0] r; int lat; bit rv;
      pair_bad = 0;
      do_op(1'b1, a, d, r, lat, rv);
      shadow[a] = d;
      chk(mem[a] == d, "R6 stored word", mem[a], d);
      chk(!rv, "R6 no rd_valid on write", rv, 0);
      chk(lat == LAT, "R7 write latency", lat, LAT);
      chk(!pair_bad && last_clr_addr == a && last_set_addr == a, "R1 write lines", last_set_addr, a);
   endtask

   task automatic host_read(input logic [5:0] a);
      logic [7:0] r; int lat; bit rv;
      pair_bad = 0;
      do_op(1'b0, a, 8'h00, r, lat, rv);
      chk(r == shadow[a], "R4 read data", r, shadow[a]);
      chk(rv, "R7 rd_valid with ready", rv, 1);
      chk(lat == LAT, "R7 read latency", lat, LAT);
      chk(mem[a] == shadow[a], "R5 restored word", mem[a], shadow[a]);
      chk(!pair_bad && last_clr_addr == a && last_set_addr == a, "R1 read lines", last_clr_addr, a);
   endtask

   function automatic logic [7:0] fill_pat(input int i);
      return 8'((i * 37) ^ 8'h5C);
   endfunction

   initial begin
      void'($urandom(32'd7731));
      for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R11 reset values
      chk(row_sel_n == 8'hFF && col_sel_n == 8'hFF, "R11 selects idle", row_sel_n, 8'hFF);
      chk(!drive_pol && inhibit == 0 && !sense_strobe, "R11 drive outputs", inhibit, 0);
      chk(!rd_valid && !test_err, "R11 flags", test_err, 0);
      chk(req_ready, "R11 ready", req_ready, 1);
      rst_n = 1;
      @(negedge clk);

      // directed corners
      host_write(6'd0, 8'hA5);
      host_read(6'd0);
      host_read(6'd0);
      host_write(6'd63, 8'h00);
      host_read(6'd63);
      host_write(6'd9, 8'hFF);
      host_read(6'd9);
      host_write(6'd9, 8'h01);
      host_read(6'd9);

      for (int i = 0; i < 64; i++) host_write(6'(i), fill_pat(i));
      for (int k = 0; k < 90; k++) begin
         logic [5:0] a;
         a = 6'($urandom_range(0, 63));
         if ($urandom_range(0, 1) == 1) host_write(a, 8'($urandom));
         else host_read(a);
      end
      chk(!inh_bad, "R8 inhibit while pol 0", inh_bad, 0);
      chk(!pol_bad, "R3 polarity quiet", pol_bad, 0);

      // self-test
      test_addr  = 6'd21;
      pulses     = 0;
      watch_addr = 1;
      @(negedge clk);
      test_en = 1;
      @(negedge clk);
      chk(!req_ready, "R9 ready low in test", req_ready, 0);
      repeat (700) @(negedge clk);
      chk(pulses >= 16, "R9 self-test activity", pulses, 16);
      chk(far_pulses == 0, "R9 only test address", far_pulses, 0);
      chk(saw_zero && saw_ones, "R9 both patterns", {saw_zero, saw_ones}, 2'b11);
      chk(!test_err, "R10 clean run", test_err, 0);
      stuck_addr = 6'd21;
      stuck_mask = 8'h08;
      repeat (700) @(negedge clk);
      chk(test_err, "R10 mismatch flagged", test_err, 1);
      test_en = 0;
      watch_addr = 0;
      stuck_mask = 8'h00;
      host_write(6'd21, 8'h3C);
      host_read(6'd21);
      chk(test_err, "R10 flag sticky", test_err, 1);
      chk(!inh_bad && !pol_bad, "R8 R3 in test mode", {inh_bad, pol_bad}, 0);

      rst_n = 0;
      @(negedge clk);
      chk(!test_err && req_ready, "R11 reset clears flag", test_err, 0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule